// File: doc/BRIEF.md
# Host Address Decoder with DRAM Reclaim

This block sits on the host request path and decides, for every 36-bit memory or I/O request, which of four destinations serves it: main DRAM, the on-chip register windows, the PCI Express port, or the default downstream interface. For DRAM hits it also produces the physical DRAM address. That address differs from the host address when a request above 4 GB is folded back onto the DRAM that lies hidden under the low memory hole.

A small set of 32-bit configuration registers sets the decode. They are written and read back over a simple configuration bus. Requests are decoded in one stage and the result is registered. Each response appears exactly one clock after its request. A separate flag marks requests that no window claims and that lie outside the compatibility space, such as memory above 4 GB or I/O beyond the I/O range. Those requests still leave on the downstream route.

Top module: `host_addr_decoder`

## Requirements
- R1: After a synchronous reset, rsp_valid is 0, rsp_target is 3 (downstream), rsp_unclaimed is 0 and rsp_dram_addr is 0. All windows come up inactive: each base/limit register reads 0x0000FFFF, the I/O window reads 0x000000FF, the reclaim base reads 0x0000FFFF, and every other register reads 0.
- R2: Each request produces its response on the clock edge that follows the one that samples it: rsp_valid equals req_valid one cycle earlier. While req_valid is 0, the response fields read target 3, unclaimed 0 and address 0.
- R3: A memory request at or above 1 MB and below 4 GB goes to DRAM (target 0) with an unchanged address when its MB index is below the low-DRAM top (register 0, bits [15:0], in MB). Otherwise it goes downstream with unclaimed 0.
- R4: A memory request whose MB index lies within [reclaim base, reclaim limit] goes to DRAM at address (low-DRAM top × 1 MB) + (address − reclaim base × 1 MB). Register 1 bits [15:0] hold the reclaim base and register 2 bits [15:0] the inclusive limit, both in MB. The window is active only when base ≥ 4096 MB and base ≤ limit.
- R5: A DRAM response never carries an address of 8 GB or more. A reclaim translation reaching 8 GB falls through to downstream with unclaimed 1. rsp_dram_addr is 0 for every target other than DRAM.
- R6: Three fixed register windows are decoded, each claiming with target 1: offset 3 is 4 KB, offset 4 is 16 KB and offset 5 is 4 KB. In each, bit 0 enables the window and bits [31:8] hold address bits [35:12] of a size-aligned base.
- R7: The configuration window (offset 6) claims with target 1. It uses bit 0 as enable, bits [31:8] as base address bits [35:12], and bits [2:1] as size: 0 selects 256 MB, 1 selects 128 MB, and 2 or 3 select 64 MB.
- R8: The PCI Express port (target 2) claims memory inside any of three windows: offsets 7, 8 and 9. Each has base in bits [15:0] and inclusive limit in bits [31:16], both in MB. A window is active only when base ≤ limit.
- R9: An I/O request goes to the PCI Express port when address bits [19:12] lie within the window at offset 10 (base in bits [7:0], limit in bits [23:16], 4 KB units, active when base ≤ limit). Any other I/O request goes downstream. An I/O address above 0x10002 goes downstream with unclaimed 1, and I/O never reaches DRAM or a register window.
- R10: Below 1 MB, memory is split into 16 segments of 64 KB. Segment i has a 2-bit attribute at bits [2i+1:2i] of offset 11. Bit 0 sends reads to DRAM and bit 1 sends writes to DRAM: 00 disabled, 01 read-only, 10 write-only, 11 read/write. A direction whose bit is clear goes downstream.
- R11: When windows overlap, the first match in this order wins: register windows (R6), configuration window (R7), PCI Express windows (R8), DRAM ranges (R10, R3, R4), downstream.
- R12: A memory request at or above 4 GB that nothing claims goes downstream with unclaimed 1.
- R13: A configuration write at offset cfg_addr (0 to 11) takes effect on the next request cycle. Writes to offsets 12 to 15 are dropped. cfg_rdata shows the register selected by cfg_addr one cycle later, and reads 0 for offsets 12 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Registered read data for cfg_addr |
| req_valid | input | 1 | Request present |
| req_addr | input | 36 | Host byte address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_is_io | input | 1 | 1 for I/O space, 0 for memory |
| rsp_valid | output | 1 | Response present |
| rsp_target | output | 2 | 0 DRAM, 1 register window, 2 PCI Express, 3 downstream |
| rsp_dram_addr | output | 33 | Physical DRAM address, 0 if not DRAM |
| rsp_unclaimed | output | 1 | No valid target found |

## Verification
The bench builds the decoder with its default parameters: 36-bit addresses, an 8 GB DRAM ceiling, sixteen 64 KB legacy segments and 32-bit configuration words. With these values one programmed map reaches every kind of boundary at byte precision. That includes the last byte of the reclaim window, the exact 8 GB translation cut-off, the I/O top at 0x10002, the edges of each register window, and a segment of every attribute kind. Reprogramming between directed phases then moves windows on top of one another, which exercises each step of the priority order and the three sizes of the configuration window.

// File: rtl/hdec_pkg.sv
package hdec_pkg;

  typedef enum logic [1:0] {
    TGT_DRAM = 2'd0,
    TGT_REG  = 2'd1,
    TGT_PCIE = 2'd2,
    TGT_DOWN = 2'd3
  } tgt_e;

  // configuration register offsets
  localparam int REG_TOLUD  = 0;
  localparam int REG_RBASE  = 1;
  localparam int REG_RLIM   = 2;
  localparam int REG_BAR0   = 3;  // three fixed-size register windows
  localparam int NUM_BAR    = 3;
  localparam int REG_CFGW   = 6;
  localparam int REG_PWIN0  = 7;  // three PCI Express memory windows
  localparam int NUM_PWIN   = 3;
  localparam int REG_IOWIN  = 10;
  localparam int REG_SEG    = 11;
  localparam int NREG       = 12;

endpackage

// File: rtl/hdec_cfg_regs.sv
module hdec_cfg_regs
  import hdec_pkg::*;
#(
  parameter int CFG_AW = 4,
  parameter int DW     = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [CFG_AW-1:0]        cfg_addr,
  input  logic [DW-1:0]            cfg_wdata,
  output logic [DW-1:0]            cfg_rdata,
  output logic [NREG-1:0][DW-1:0]  regs_o
);

  localparam int HALF = DW / 2;

  // windows start inactive: base above limit
  function automatic logic [DW-1:0] reset_word(int idx);
    logic [DW-1:0] w;
    w = '0;
    if (idx == REG_RBASE || (idx >= REG_PWIN0 && idx < REG_PWIN0 + NUM_PWIN))
      w[HALF-1:0] = '1;
    else if (idx == REG_IOWIN)
      w[7:0] = '1;
    return w;
  endfunction

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs_o[i] <= reset_word(i);
      else if (cfg_we && cfg_addr == CFG_AW'(i))
        regs_o[i] <= cfg_wdata;
    end
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NREG; i++)
      if (cfg_addr == CFG_AW'(i)) rd_mux = regs_o[i];
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_mux;
  end

endmodule

// File: rtl/hdec_range_match.sv
module hdec_range_match #(
  parameter int W = 16
) (
  input  logic [W-1:0] key,
  input  logic [W-1:0] base,
  input  logic [W-1:0] limit,
  output logic         hit
);

  assign hit = (base <= limit) && (key >= base) && (key <= limit);

endmodule

// File: rtl/hdec_bar_match.sv
module hdec_bar_match #(
  parameter int ADDR_W = 36,
  parameter int LG2_W  = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              en,
  input  logic [ADDR_W-1:0] base,
  input  logic [LG2_W-1:0]  size_lg2,
  output logic              hit
);

  logic [ADDR_W-1:0] diff;
  assign diff = (addr ^ base) >> size_lg2;
  assign hit  = en && (diff == '0);

endmodule

// File: rtl/host_addr_decoder.sv
module host_addr_decoder
  import hdec_pkg::*;
#(
  parameter int ADDR_W   = 36,
  parameter int DRAM_AW  = 33,
  parameter int CFG_AW   = 4,
  parameter int DW       = 32,
  parameter int NSEG     = 16,
  parameter int IO_LIMIT = 'h10002
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [DW-1:0]      cfg_wdata,
  output logic [DW-1:0]      cfg_rdata,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_write,
  input  logic               req_is_io,
  output logic               rsp_valid,
  output logic [1:0]         rsp_target,
  output logic [DRAM_AW-1:0] rsp_dram_addr,
  output logic               rsp_unclaimed
);

  localparam int MB_LSB    = 20;
  localparam int MB_W      = ADDR_W - MB_LSB;
  localparam int SEG_W     = $clog2(NSEG);
  localparam int SEG_LSB   = MB_LSB - SEG_W;
  localparam int HALF      = DW / 2;
  localparam int BAR_LSB   = 12;
  localparam int FLD_LSB   = 8;
  localparam int LG2_W     = $clog2(ADDR_W + 1);
  localparam int IO_LSB    = 12;
  localparam int IO_KW     = 8;
  localparam int CFG_LG2_MAX = 28;
  localparam logic [MB_W-1:0]   FOUR_G_MB = MB_W'(4096);
  localparam logic [ADDR_W:0]   DRAM_TOP  = (ADDR_W+1)'(1) << DRAM_AW;
  localparam int BAR_LG2 [NUM_BAR] = '{12, 14, 12};

  logic [NREG-1:0][DW-1:0] cfg_q;

  hdec_cfg_regs #(.CFG_AW(CFG_AW), .DW(DW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .regs_o   (cfg_q)
  );

  function automatic logic [ADDR_W-1:0] win_base(logic [DW-1:0] w);
    return ADDR_W'({w[DW-1:FLD_LSB], {BAR_LSB{1'b0}}});
  endfunction

  // ---------------- field extraction ----------------
  logic [MB_W-1:0] addr_mb, tolud_mb, rbase_mb, rlim_mb;
  assign addr_mb  = req_addr[ADDR_W-1:MB_LSB];
  assign tolud_mb = cfg_q[REG_TOLUD][MB_W-1:0];
  assign rbase_mb = cfg_q[REG_RBASE][MB_W-1:0];
  assign rlim_mb  = cfg_q[REG_RLIM][MB_W-1:0];

  // ---------------- register windows ----------------
  logic [NUM_BAR-1:0] bar_hit;
  for (genvar k = 0; k < NUM_BAR; k++) begin : g_bar
    hdec_bar_match #(.ADDR_W(ADDR_W), .LG2_W(LG2_W)) u_bar (
      .addr    (req_addr),
      .en      (cfg_q[REG_BAR0+k][0]),
      .base    (win_base(cfg_q[REG_BAR0+k])),
      .size_lg2(LG2_W'(BAR_LG2[k])),
      .hit     (bar_hit[k])
    );
  end

  // ---------------- configuration window ----------------
  logic [1:0]       cfgw_sz;
  logic [LG2_W-1:0] cfgw_lg2;
  logic             cfgw_hit;
  assign cfgw_sz = cfg_q[REG_CFGW][2:1];
  always_comb begin
    unique case (cfgw_sz)
      2'd0:    cfgw_lg2 = LG2_W'(CFG_LG2_MAX);
      2'd1:    cfgw_lg2 = LG2_W'(CFG_LG2_MAX - 1);
      default: cfgw_lg2 = LG2_W'(CFG_LG2_MAX - 2);
    endcase
  end

  hdec_bar_match #(.ADDR_W(ADDR_W), .LG2_W(LG2_W)) u_cfgw (
    .addr    (req_addr),
    .en      (cfg_q[REG_CFGW][0]),
    .base    (win_base(cfg_q[REG_CFGW])),
    .size_lg2(cfgw_lg2),
    .hit     (cfgw_hit)
  );

  // ---------------- PCI Express memory windows ----------------
  logic [NUM_PWIN-1:0] pwin_hit;
  for (genvar w = 0; w < NUM_PWIN; w++) begin : g_pwin
    hdec_range_match #(.W(MB_W)) u_pw (
      .key  (addr_mb),
      .base (cfg_q[REG_PWIN0+w][MB_W-1:0]),
      .limit(cfg_q[REG_PWIN0+w][HALF +: MB_W]),
      .hit  (pwin_hit[w])
    );
  end

  // ---------------- PCI Express I/O window ----------------
  logic io_hit;
  hdec_range_match #(.W(IO_KW)) u_iow (
    .key  (req_addr[IO_LSB +: IO_KW]),
    .base (cfg_q[REG_IOWIN][IO_KW-1:0]),
    .limit(cfg_q[REG_IOWIN][HALF +: IO_KW]),
    .hit  (io_hit)
  );

  // ---------------- reclaim window ----------------
  logic            rwin_hit, rec_ok;
  logic [ADDR_W:0] rec_xl;
  hdec_range_match #(.W(MB_W)) u_rwin (
    .key  (addr_mb),
    .base (rbase_mb),
    .limit(rlim_mb),
    .hit  (rwin_hit)
  );

  assign rec_xl = {1'b0, tolud_mb, {MB_LSB{1'b0}}} + {1'b0, req_addr}
                - {1'b0, rbase_mb, {MB_LSB{1'b0}}};
  assign rec_ok = rwin_hit && (rbase_mb >= FOUR_G_MB) && (rec_xl < DRAM_TOP);

  // ---------------- legacy segments and low DRAM ----------------
  logic             below_4g, low_1m, low_dram, seg_dram;
  logic [SEG_W-1:0] seg_idx;
  logic [1:0]       seg_attr;
  assign below_4g = addr_mb < FOUR_G_MB;
  assign low_1m   = addr_mb == '0;
  assign low_dram = below_4g && !low_1m && (addr_mb < tolud_mb);
  assign seg_idx  = req_addr[MB_LSB-1:SEG_LSB];
  assign seg_attr = cfg_q[REG_SEG][{seg_idx, 1'b0} +: 2];
  assign seg_dram = req_write ? seg_attr[1] : seg_attr[0];

  // ---------------- priority resolve ----------------
  tgt_e               nxt_tgt;
  logic               nxt_unc;
  logic [DRAM_AW-1:0] nxt_dram;

  always_comb begin
    nxt_tgt  = TGT_DOWN;
    nxt_unc  = 1'b0;
    nxt_dram = '0;
    if (!req_valid) begin
      nxt_tgt = TGT_DOWN;
    end else if (req_is_io) begin
      if (req_addr > ADDR_W'(IO_LIMIT)) nxt_unc = 1'b1;
      else if (io_hit)                  nxt_tgt = TGT_PCIE;
    end else if (|bar_hit) begin
      nxt_tgt = TGT_REG;
    end else if (cfgw_hit) begin
      nxt_tgt = TGT_REG;
    end else if (|pwin_hit) begin
      nxt_tgt = TGT_PCIE;
    end else if (low_1m) begin
      if (seg_dram) begin
        nxt_tgt  = TGT_DRAM;
        nxt_dram = DRAM_AW'(req_addr);
      end
    end else if (low_dram) begin
      nxt_tgt  = TGT_DRAM;
      nxt_dram = DRAM_AW'(req_addr);
    end else if (rec_ok) begin
      nxt_tgt  = TGT_DRAM;
      nxt_dram = rec_xl[DRAM_AW-1:0];
    end else begin
      nxt_unc = !below_4g;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_target    <= TGT_DOWN;
      rsp_dram_addr <= '0;
      rsp_unclaimed <= 1'b0;
    end else begin
      rsp_valid     <= req_valid;
      rsp_target    <= nxt_tgt;
      rsp_dram_addr <= nxt_dram;
      rsp_unclaimed <= nxt_unc;
    end
  end

endmodule

// File: rtl/hdec_checker.sv
module hdec_checker
  import hdec_pkg::*;
#(
  parameter int DRAM_AW = 33
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_is_io,
  input logic               rsp_valid,
  input logic [1:0]         rsp_target,
  input logic [DRAM_AW-1:0] rsp_dram_addr,
  input logic               rsp_unclaimed
);

  // R2: a response follows each request by one cycle
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R2: no response without a request
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R9: I/O requests only reach the PCI Express port or downstream
  a_r9_io_not_memory: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_is_io) |=>
      (rsp_target == TGT_PCIE || rsp_target == TGT_DOWN));

  // R12: an unclaimed request always leaves downstream
  a_r12_unclaimed_down: assert property (@(posedge clk) disable iff (rst)
    rsp_unclaimed |-> (rsp_target == TGT_DOWN));

  // R5: a DRAM address appears only with a DRAM target
  a_r5_addr_only_dram: assert property (@(posedge clk) disable iff (rst)
    (rsp_target != TGT_DRAM) |-> (rsp_dram_addr == '0));

endmodule

bind host_addr_decoder hdec_checker #(.DRAM_AW(DRAM_AW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_is_io    (req_is_io),
  .rsp_valid    (rsp_valid),
  .rsp_target   (rsp_target),
  .rsp_dram_addr(rsp_dram_addr),
  .rsp_unclaimed(rsp_unclaimed)
);

// File: tb/tb_host_addr_decoder.sv
module tb_host_addr_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NVEC       = 24;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        req_valid;
  logic [35:0] req_addr;
  logic        req_write;
  logic        req_is_io;
  logic        rsp_valid;
  logic [1:0]  rsp_target;
  logic [32:0] rsp_dram_addr;
  logic        rsp_unclaimed;

  int checks = 0;
  int bad    = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_addr_decoder dut (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write), .req_is_io(req_is_io),
    .rsp_valid(rsp_valid), .rsp_target(rsp_target),
    .rsp_dram_addr(rsp_dram_addr), .rsp_unclaimed(rsp_unclaimed)
  );

  // {tag[4], write, io, addr[36], target[2], unclaimed, dram[33]}
  localparam logic [77:0] VEC [NVEC] = '{
    {4'd10, 1'b0, 1'b0, 36'h0_0000_0000, 2'd0, 1'b0, 33'h0_0000_0000},
    {4'd3,  1'b0, 1'b0, 36'h0_0010_0000, 2'd0, 1'b0, 33'h0_0010_0000},
    {4'd3,  1'b1, 1'b0, 36'h0_BFFF_FFFF, 2'd0, 1'b0, 33'h0_BFFF_FFFF},
    {4'd3,  1'b0, 1'b0, 36'h0_C000_0000, 2'd3, 1'b0, 33'h0},
    {4'd6,  1'b0, 1'b0, 36'h0_FED1_0010, 2'd1, 1'b0, 33'h0},
    {4'd6,  1'b0, 1'b0, 36'h0_FED1_7FFC, 2'd1, 1'b0, 33'h0},
    {4'd6,  1'b0, 1'b0, 36'h0_FED1_8FFF, 2'd1, 1'b0, 33'h0},
    {4'd6,  1'b0, 1'b0, 36'h0_FED1_9000, 2'd3, 1'b0, 33'h0},
    {4'd7,  1'b0, 1'b0, 36'h0_EFFF_FFFF, 2'd1, 1'b0, 33'h0},
    {4'd8,  1'b0, 1'b0, 36'h0_D800_0000, 2'd2, 1'b0, 33'h0},
    {4'd4,  1'b0, 1'b0, 36'h1_0000_0000, 2'd0, 1'b0, 33'h0_C000_0000},
    {4'd4,  1'b0, 1'b0, 36'h1_3FFF_FFFF, 2'd0, 1'b0, 33'h0_FFFF_FFFF},
    {4'd12, 1'b0, 1'b0, 36'h1_4000_0000, 2'd3, 1'b1, 33'h0},
    {4'd8,  1'b0, 1'b0, 36'h2_0000_0000, 2'd2, 1'b0, 33'h0},
    {4'd8,  1'b0, 1'b0, 36'h8_0FF0_0000, 2'd2, 1'b0, 33'h0},
    {4'd9,  1'b0, 1'b1, 36'h0_0000_2000, 2'd2, 1'b0, 33'h0},
    {4'd9,  1'b1, 1'b1, 36'h0_0000_4000, 2'd3, 1'b0, 33'h0},
    {4'd9,  1'b0, 1'b1, 36'h0_0001_0003, 2'd3, 1'b1, 33'h0},
    {4'd9,  1'b0, 1'b1, 36'h0_0001_0002, 2'd3, 1'b0, 33'h0},
    {4'd10, 1'b0, 1'b0, 36'h0_000A_0000, 2'd3, 1'b0, 33'h0},
    {4'd10, 1'b0, 1'b0, 36'h0_000C_0000, 2'd0, 1'b0, 33'h0_000C_0000},
    {4'd10, 1'b1, 1'b0, 36'h0_000C_0000, 2'd3, 1'b0, 33'h0},
    {4'd10, 1'b0, 1'b0, 36'h0_000D_0000, 2'd3, 1'b0, 33'h0},
    {4'd10, 1'b1, 1'b0, 36'h0_000D_FFFF, 2'd0, 1'b0, 33'h0_000D_FFFF}
  };

  function automatic string tag_name(int n);
    case (n)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";  10: return "R10"; 11: return "R11"; 12: return "R12";
      13: return "R13";
      default: return "R?";
    endcase
  endfunction

  task automatic summary();
    $display("test done: total=%0d bad=%0d", checks, bad);
  endtask

  task automatic cfg_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_check(int tag, logic [3:0] a, logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    checks++;
    if (cfg_rdata !== exp) begin
      bad++;
      $display("FAIL %s: cfg[%0d] got %h expected %h", tag_name(tag), a, cfg_rdata, exp);
    end
  endtask

  task automatic run_req(int tag, logic w, logic io, logic [35:0] a,
                         logic [1:0] et, logic eu, logic [32:0] ed);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_is_io = io; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    checks++;
    if (rsp_valid !== 1'b1 || rsp_target !== et || rsp_unclaimed !== eu || rsp_dram_addr !== ed) begin
      bad++;
      $display("FAIL %s: addr=%h got v=%b tgt=%0d unc=%b dram=%h expected v=1 tgt=%0d unc=%b dram=%h",
               tag_name(tag), a, rsp_valid, rsp_target, rsp_unclaimed, rsp_dram_addr, et, eu, ed);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL R2: watchdog expired after %0d cycles, expected completion", WATCHDOG);
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_is_io = 1'b0;
    repeat (4) @(negedge clk);
    // R1: reset state of outputs
    checks++;
    if (rsp_valid !== 1'b0 || rsp_target !== 2'd3 || rsp_unclaimed !== 1'b0 || rsp_dram_addr !== '0) begin
      bad++;
      $display("FAIL R1: got v=%b tgt=%0d unc=%b dram=%h expected v=0 tgt=3 unc=0 dram=0",
               rsp_valid, rsp_target, rsp_unclaimed, rsp_dram_addr);
    end
    rst = 1'b0;
    // R1: reset register values, all windows inactive
    cfg_check(1, 4'd7, 32'h0000_FFFF);
    cfg_check(1, 4'd10, 32'h0000_00FF);
    cfg_check(1, 4'd1, 32'h0000_FFFF);
    run_req(1, 1'b0, 1'b0, 36'h0_0010_0000, 2'd3, 1'b0, 33'h0);
    run_req(1, 1'b0, 1'b0, 36'h1_0000_0000, 2'd3, 1'b1, 33'h0);

    // program the map
    cfg_write(4'd0,  32'h0000_0C00);   // low DRAM top 3 GB
    cfg_write(4'd1,  32'h0000_1000);   // reclaim base 4 GB
    cfg_write(4'd2,  32'h0000_13FF);   // reclaim limit 5 GB - 1 MB
    cfg_write(4'd3,  32'h0FED_1001);
    cfg_write(4'd4,  32'h0FED_1401);
    cfg_write(4'd5,  32'h0FED_1801);
    cfg_write(4'd6,  32'h0E00_0001);   // 256 MB at 0xE000_0000
    cfg_write(4'd7,  32'h0DFF_0D00);
    cfg_write(4'd8,  32'h20FF_2000);
    cfg_write(4'd9,  32'h80FF_8000);
    cfg_write(4'd10, 32'h0003_0002);
    cfg_write(4'd11, 32'hF90F_FFFF);
    cfg_write(4'd13, 32'hDEAD_BEEF);   // R13: dropped

    // R13: readback and dropped write
    cfg_check(13, 4'd0, 32'h0000_0C00);
    cfg_check(13, 4'd11, 32'hF90F_FFFF);
    cfg_check(13, 4'd13, 32'h0);

    for (int i = 0; i < NVEC; i++)
      run_req(int'(VEC[i][77:74]), VEC[i][73], VEC[i][72], VEC[i][71:36],
              VEC[i][35:34], VEC[i][33], VEC[i][32:0]);

    // R2: idle cycle gives no response
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_target !== 2'd3) begin
      bad++;
      $display("FAIL R2: idle got v=%b tgt=%0d expected v=0 tgt=3", rsp_valid, rsp_target);
    end

    // R5: translation cap at 8 GB
    cfg_write(4'd2, 32'h0000_3FFF);
    run_req(5, 1'b0, 1'b0, 36'h2_3FF0_0000, 2'd0, 1'b0, 33'h1_FFF0_0000);
    run_req(5, 1'b0, 1'b0, 36'h2_4000_0000, 2'd3, 1'b1, 33'h0);

    // R11: priority between overlapping windows
    cfg_write(4'd3, 32'h0400_0001);    // register window inside low DRAM
    run_req(11, 1'b0, 1'b0, 36'h0_4000_0000, 2'd1, 1'b0, 33'h0);
    cfg_write(4'd7, 32'h01FF_0100);    // PCIe window over low DRAM
    run_req(11, 1'b0, 1'b0, 36'h0_1000_0000, 2'd2, 1'b0, 33'h0);
    cfg_write(4'd7, 32'h0EFF_0E00);    // PCIe window under config window
    run_req(11, 1'b0, 1'b0, 36'h0_E000_0000, 2'd1, 1'b0, 33'h0);

    // R7: smaller configuration window sizes
    cfg_write(4'd6, 32'h0E00_0003);    // 128 MB
    run_req(7, 1'b0, 1'b0, 36'h0_E7FF_FFFF, 2'd1, 1'b0, 33'h0);
    run_req(7, 1'b0, 1'b0, 36'h0_E800_0000, 2'd2, 1'b0, 33'h0);
    cfg_write(4'd6, 32'h0E00_0005);    // 64 MB
    run_req(7, 1'b0, 1'b0, 36'h0_E3FF_FFFC, 2'd1, 1'b0, 33'h0);
    run_req(7, 1'b0, 1'b0, 36'h0_E400_0000, 2'd2, 1'b0, 33'h0);

    // R6: disabled register window no longer claims
    cfg_write(4'd3, 32'h0400_0000);
    run_req(6, 1'b0, 1'b0, 36'h0_4000_0000, 2'd0, 1'b0, 33'h0_4000_0000);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule